// File: doc/BRIEF.md
# Spread-Spectrum Triangle Offset Generator

This block produces the modulation profile for a spread-spectrum clock. It emits a signed offset word that a PLL feedback divider adds to its nominal ratio. The offset traces a triangle: it climbs by a programmable rising step on every modulation tick until it meets the upper limit of the selected spread shape. It then falls by a separately programmed falling step until it meets the lower limit, and the cycle repeats.

The rising step is an unsigned 4-bit value. The falling step is a 4-bit two's complement number whose negation is the magnitude. A prescaler divides the system clock down to a 280 ns timebase, and a 6-bit period setting stretches each tick to a whole number of timebase units. A 2-bit shape code chooses one of four limit pairs. Two shapes spread only downward from the nominal frequency, and two spread symmetrically around it. When spreading is disabled, the word returns to zero on the next tick.

Top module: `spread_profile_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `spreadOffset` is zero.
- R2: The offset changes only on a modulation tick. Ticks fall every (periodSel+1)×PRESCALE system clocks, where PRESCALE is the number of clocks in one 280 ns unit (28 at 100 MHz). The new value is visible in the cycle after the tick edge.
- R3: While rising, each tick adds `upStep` to the offset. If the sum reaches or passes the upper limit, the offset is set to that limit and the ramp turns to falling.
- R4: `downStepTc` is two's complement. The falling magnitude is its negation modulo 16: 1111→1, 1110→2, 1001→7, 1000→8, 0001→15. While falling, each tick subtracts that magnitude. If the result reaches or passes the lower limit, the offset is set to that limit and the ramp turns to rising.
- R5: The limits depend on `spreadType` (SPAN = 64 by default): 00 gives [−SPAN, 0]; 01 gives [−SPAN/2, 0]; 10 gives [−SPAN/2, +SPAN/2]; 11 gives [−SPAN/4, +SPAN/4].
- R6: In the two downward shapes (code bit 1 = 0), an offset that is zero or negative never becomes positive.
- R7: A tick seen with `ssEnable` low sets the offset to zero. The offset stays zero for as long as the enable stays low.
- R8: After disabled ticks, the first enabled tick starts from zero in the rising direction.
- R9: A step of zero (rising value 0000 or falling code 0000) leaves the offset unchanged on a tick in that direction, unless a limit is met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ssEnable | input | 1 | Spread modulation on when high |
| spreadType | input | 2 | Spread shape code (see R5) |
| upStep | input | STEP_W | Rising step, unsigned |
| downStepTc | input | STEP_W | Falling step, two's complement |
| periodSel | input | PERIOD_W | Tick length minus one, in 280 ns units |
| spreadOffset | output | OFFSET_W | Signed frequency offset word |

## Verification
The assertions assume nothing about when the inputs change. Every control input may move on any cycle, including mid-ramp. The bounds and sign checks therefore rely only on clamping and direction reversal, and they must hold even when the shape code changes while the offset lies outside the new limits. The tick-spacing property takes for granted that PRESCALE is above one. The bench changes inputs only on falling edges. It keeps periods short in the random segments so that many ramps fit the run, and it uses the full 6-bit range only in the directed interval measurement.

// File: rtl/spread_profile_pkg.sv
package spread_profile_pkg;

  // Spread shape codes; the encoding is decoded by the datapath bound mux.
  typedef enum logic [1:0] {
    SPREAD_DOWN_WIDE     = 2'b00,
    SPREAD_DOWN_NARROW   = 2'b01,
    SPREAD_CENTER_WIDE   = 2'b10,
    SPREAD_CENTER_NARROW = 2'b11
  } spread_kind_e;

  typedef enum logic {
    RAMP_RISE = 1'b0,
    RAMP_FALL = 1'b1
  } ramp_dir_e;

  // Strobes from control to datapath, one cycle wide on a tick edge.
  typedef struct packed {
    logic tick;
    logic clear;
    logic stepUp;
    logic stepDown;
  } ramp_strobe_t;

endpackage

// File: rtl/spread_profile_ctrl.sv
module spread_profile_ctrl
  import spread_profile_pkg::*;
#(
  parameter int PRESCALE = 28,
  parameter int PERIOD_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ssEnable,
  input  logic [PERIOD_W-1:0] periodSel,
  input  logic                hitHi,
  input  logic                hitLo,
  output ramp_strobe_t        strobe
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0]    preCnt;
  logic [PERIOD_W-1:0] unitCnt;
  logic                unitDone;
  logic                tickNow;
  ramp_dir_e           dirQ;

  // One timebase unit ends on the last prescaler count.
  assign unitDone = (preCnt == PRE_LAST);
  // Compare with >= so a period lowered mid-count still ends promptly.
  assign tickNow  = unitDone && (unitCnt >= periodSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (unitDone) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unitCnt <= '0;
    end else if (tickNow) begin
      unitCnt <= '0;
    end else if (unitDone) begin
      unitCnt <= unitCnt + 1'b1;
    end
  end

  // Ramp direction: reversal on meeting a limit, forced rising while idle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ <= RAMP_RISE;
    end else if (tickNow) begin
      if (!ssEnable) begin
        dirQ <= RAMP_RISE;
      end else if ((dirQ == RAMP_RISE) && hitHi) begin
        dirQ <= RAMP_FALL;
      end else if ((dirQ == RAMP_FALL) && hitLo) begin
        dirQ <= RAMP_RISE;
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.tick     = tickNow;
    strobe.clear    = tickNow && !ssEnable;
    strobe.stepUp   = tickNow && ssEnable && (dirQ == RAMP_RISE);
    strobe.stepDown = tickNow && ssEnable && (dirQ == RAMP_FALL);
  end

endmodule

// File: rtl/spread_profile_dpath.sv
module spread_profile_dpath
  import spread_profile_pkg::*;
#(
  parameter int SPAN     = 64,
  parameter int STEP_W   = 4,
  parameter int OFFSET_W = $clog2(SPAN) + 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ramp_strobe_t               strobe,
  input  logic [1:0]                 spreadType,
  input  logic [STEP_W-1:0]          upStep,
  input  logic [STEP_W-1:0]          downStepTc,
  output logic                       hitHi,
  output logic                       hitLo,
  output logic signed [OFFSET_W-1:0] offsetQ
);

  localparam int EXT_W = OFFSET_W + 1;
  localparam logic signed [EXT_W-1:0] LIM_FULL = EXT_W'(SPAN);
  localparam logic signed [EXT_W-1:0] LIM_HALF = EXT_W'(SPAN / 2);
  localparam logic signed [EXT_W-1:0] LIM_QTR  = EXT_W'(SPAN / 4);
  localparam logic signed [EXT_W-1:0] LIM_ZERO = '0;

  logic signed [EXT_W-1:0] hiLim, loLim;
  logic signed [EXT_W-1:0] curExt, upExt, dnExt, candUp, candDn;
  logic        [STEP_W-1:0] downMag;

  // Limit pair per shape code.
  always_comb begin
    unique case (spread_kind_e'(spreadType))
      SPREAD_DOWN_WIDE:     begin hiLim = LIM_ZERO; loLim = -LIM_FULL; end
      SPREAD_DOWN_NARROW:   begin hiLim = LIM_ZERO; loLim = -LIM_HALF; end
      SPREAD_CENTER_WIDE:   begin hiLim = LIM_HALF; loLim = -LIM_HALF; end
      default:              begin hiLim = LIM_QTR;  loLim = -LIM_QTR;  end
    endcase
  end

  // Falling magnitude is the two's complement negation of the field.
  assign downMag = (~downStepTc) + {{(STEP_W-1){1'b0}}, 1'b1};

  assign curExt = {offsetQ[OFFSET_W-1], offsetQ};
  assign upExt  = $signed({{(EXT_W-STEP_W){1'b0}}, upStep});
  assign dnExt  = $signed({{(EXT_W-STEP_W){1'b0}}, downMag});
  assign candUp = curExt + upExt;
  assign candDn = curExt - dnExt;
  assign hitHi  = (candUp >= hiLim);
  assign hitLo  = (candDn <= loLim);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsetQ <= '0;
    end else if (strobe.clear) begin
      offsetQ <= '0;
    end else if (strobe.stepUp) begin
      offsetQ <= hitHi ? hiLim[OFFSET_W-1:0] : candUp[OFFSET_W-1:0];
    end else if (strobe.stepDown) begin
      offsetQ <= hitLo ? loLim[OFFSET_W-1:0] : candDn[OFFSET_W-1:0];
    end
  end

endmodule

// File: rtl/spread_profile_gen.sv
module spread_profile_gen
  import spread_profile_pkg::*;
#(
  parameter int SPAN     = 64,
  parameter int PRESCALE = 28,
  parameter int STEP_W   = 4,
  parameter int PERIOD_W = 6,
  parameter int OFFSET_W = $clog2(SPAN) + 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       ssEnable,
  input  logic [1:0]                 spreadType,
  input  logic [STEP_W-1:0]          upStep,
  input  logic [STEP_W-1:0]          downStepTc,
  input  logic [PERIOD_W-1:0]        periodSel,
  output logic signed [OFFSET_W-1:0] spreadOffset
);

  ramp_strobe_t ctrlStrobe;
  logic         hitHi;
  logic         hitLo;
  logic         tickPulse;

  assign tickPulse = ctrlStrobe.tick;

  spread_profile_ctrl #(
    .PRESCALE (PRESCALE),
    .PERIOD_W (PERIOD_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ssEnable  (ssEnable),
    .periodSel (periodSel),
    .hitHi     (hitHi),
    .hitLo     (hitLo),
    .strobe    (ctrlStrobe)
  );

  spread_profile_dpath #(
    .SPAN     (SPAN),
    .STEP_W   (STEP_W),
    .OFFSET_W (OFFSET_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (ctrlStrobe),
    .spreadType (spreadType),
    .upStep     (upStep),
    .downStepTc (downStepTc),
    .hitHi      (hitHi),
    .hitLo      (hitLo),
    .offsetQ    (spreadOffset)
  );

endmodule

// File: rtl/spread_profile_chk.sv
module spread_profile_chk #(
  parameter int SPAN     = 64,
  parameter int PRESCALE = 28,
  parameter int OFFSET_W = $clog2(SPAN) + 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       tick,
  input logic                       ssEnable,
  input logic [1:0]                 spreadType,
  input logic signed [OFFSET_W-1:0] spreadOffset
);

  logic wasIdle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wasIdle <= 1'b1;
    end else if (tick) begin
      wasIdle <= !ssEnable;
    end
  end

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(spreadOffset)); // R2

  generate
    if (PRESCALE > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick); // R2
    end
  endgenerate

  AST_CLEAR_ON_DISABLE: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !ssEnable) |=> (spreadOffset == '0)); // R7

  AST_DOWN_NONPOSITIVE: assert property (@(posedge clk) disable iff (!rstN)
    (tick && ssEnable && !spreadType[1] && (spreadOffset <= 0)) |=> (spreadOffset <= 0)); // R6

  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (spreadOffset >= -SPAN) && (spreadOffset <= SPAN / 2)); // R5

  AST_RESTART_RISING: assert property (@(posedge clk) disable iff (!rstN)
    (tick && ssEnable && wasIdle) |=> (spreadOffset >= 0)); // R8

endmodule

bind spread_profile_gen spread_profile_chk #(
  .SPAN     (SPAN),
  .PRESCALE (PRESCALE),
  .OFFSET_W (OFFSET_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .tick         (tickPulse),
  .ssEnable     (ssEnable),
  .spreadType   (spreadType),
  .spreadOffset (spreadOffset)
);

// File: tb/test_spread_profile_gen.sv
module test_spread_profile_gen;

  localparam int SPAN     = 64;
  localparam int PRESCALE = 28;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ssEnable = 1'b0;
  logic [1:0]        spreadType = 2'b00;
  logic [3:0]        upStep = 4'd0;
  logic [3:0]        downStepTc = 4'd0;
  logic [5:0]        periodSel = 6'd0;
  logic signed [7:0] spreadOffset;

  int     checks = 0;
  int     failures = 0;
  string  curTag = "R1";
  bit     cmpOn = 1'b0;
  longint cycles = 0;

  // Reference state built from the requirements.
  int mPre = 0;
  int mUnits = 0;
  int mOff = 0;
  int mTicks = 0;
  bit mRising = 1'b1;

  always #5 clk = ~clk;

  spread_profile_gen i_spread_profile_gen (
    .clk          (clk),
    .rstN         (rstN),
    .ssEnable     (ssEnable),
    .spreadType   (spreadType),
    .upStep       (upStep),
    .downStepTc   (downStepTc),
    .periodSel    (periodSel),
    .spreadOffset (spreadOffset)
  );

  function automatic int hiOf(input logic [1:0] k);
    case (k)
      2'b00, 2'b01: return 0;
      2'b10:        return SPAN / 2;
      default:      return SPAN / 4;
    endcase
  endfunction

  function automatic int loOf(input logic [1:0] k);
    case (k)
      2'b00:   return -SPAN;
      2'b01:   return -SPAN / 2;
      2'b10:   return -SPAN / 2;
      default: return -SPAN / 4;
    endcase
  endfunction

  function automatic int magOf(input logic [3:0] d);
    return (d == 4'd0) ? 0 : 16 - int'(d);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: offset actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mPre = 0; mUnits = 0; mOff = 0; mRising = 1'b1;
    end else begin
      bit unitEnd;
      bit t;
      int nxt;
      unitEnd = (mPre == PRESCALE - 1);
      t = unitEnd && (mUnits >= int'(periodSel));
      mPre = unitEnd ? 0 : mPre + 1;
      if (t) mUnits = 0;
      else if (unitEnd) mUnits = mUnits + 1;
      if (t) begin
        mTicks++;
        if (!ssEnable) begin
          mOff = 0; mRising = 1'b1;
        end else if (mRising) begin
          nxt = mOff + int'(upStep);
          if (nxt >= hiOf(spreadType)) begin mOff = hiOf(spreadType); mRising = 1'b0; end
          else mOff = nxt;
        end else begin
          nxt = mOff - magOf(downStepTc);
          if (nxt <= loOf(spreadType)) begin mOff = loOf(spreadType); mRising = 1'b1; end
          else mOff = nxt;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmpOn) check(curTag, int'(spreadOffset), mOff);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected below 190000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic waitTicks(input int n);
    int target;
    target = mTicks + n;
    while (mTicks < target) @(negedge clk);
  endtask

  task automatic setIn(input bit en, input logic [1:0] k, input logic [3:0] up,
                       input logic [3:0] dn, input logic [5:0] p);
    ssEnable = en; spreadType = k; upStep = up; downStepTc = dn; periodSel = p;
  endtask

  task automatic measureGap(output int gap);
    int prev;
    int guard;
    prev = int'(spreadOffset);
    guard = 0;
    while (int'(spreadOffset) == prev && guard < 5000) begin @(negedge clk); guard++; end
    prev = int'(spreadOffset);
    gap = 0;
    while (int'(spreadOffset) == prev && gap < 5000) begin @(negedge clk); gap++; end
  endtask

  initial begin
    int gap;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", int'(spreadOffset), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", int'(spreadOffset), 0);
    cmpOn = 1'b1;

    // Centre quarter shape, rise 5, fall code 1001 (magnitude 7)
    curTag = "R3";
    setIn(1'b1, 2'b11, 4'd5, 4'b1001, 6'd1);
    waitTicks(4);  check("R3", int'(spreadOffset), 16);
    waitTicks(4);  check("R4", int'(spreadOffset), -12);
    waitTicks(1);  check("R5", int'(spreadOffset), -16);
    waitTicks(1);  check("R3", int'(spreadOffset), -11);

    // Disable clears
    curTag = "R7";
    ssEnable = 1'b0;
    waitTicks(1);  check("R7", int'(spreadOffset), 0);
    waitTicks(2);  check("R7", int'(spreadOffset), 0);

    // Wide downward shape, rise 3, fall code 1000 (magnitude 8)
    curTag = "R6";
    setIn(1'b1, 2'b00, 4'd3, 4'b1000, 6'd0);
    waitTicks(1);  check("R6", int'(spreadOffset), 0);
    waitTicks(2);  check("R4", int'(spreadOffset), -16);
    waitTicks(6);  check("R5", int'(spreadOffset), -64);
    waitTicks(1);  check("R3", int'(spreadOffset), -61);

    // Narrow downward shape, fall code 1111 (magnitude 1)
    curTag = "R5";
    ssEnable = 1'b0; waitTicks(1);
    setIn(1'b1, 2'b01, 4'd2, 4'b1111, 6'd0);
    waitTicks(33); check("R5", int'(spreadOffset), -32);
    waitTicks(1);  check("R3", int'(spreadOffset), -30);

    // Restart rising from zero
    curTag = "R8";
    ssEnable = 1'b0; waitTicks(1);
    setIn(1'b1, 2'b10, 4'd4, 4'b1111, 6'd2);
    waitTicks(1);  check("R8", int'(spreadOffset), 4);

    // Zero steps hold
    curTag = "R9";
    ssEnable = 1'b0; waitTicks(1);
    setIn(1'b1, 2'b10, 4'd0, 4'b1111, 6'd0);
    waitTicks(3);  check("R9", int'(spreadOffset), 0);
    ssEnable = 1'b0; waitTicks(1);
    setIn(1'b1, 2'b01, 4'd2, 4'b0000, 6'd0);
    waitTicks(3);  check("R9", int'(spreadOffset), 0);

    // Tick spacing at the ends of the period range
    curTag = "R2";
    ssEnable = 1'b0; waitTicks(1);
    setIn(1'b1, 2'b10, 4'd1, 4'b1111, 6'd63);
    measureGap(gap); check("R2", gap, 64 * PRESCALE);
    periodSel = 6'd0;
    measureGap(gap); check("R2", gap, PRESCALE);
    periodSel = 6'd5;
    measureGap(gap); check("R2", gap, 6 * PRESCALE);

    // Random segments, mode changes mid-ramp included
    curTag = "R5";
    for (int seg = 0; seg < 25; seg++) begin
      int len;
      setIn(($urandom_range(0, 9) < 8), 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)),
            4'($urandom_range(0, 15)), 6'($urandom_range(0, 7)));
      len = (int'(periodSel) + 1) * PRESCALE * int'($urandom_range(3, 12));
      repeat (len) @(negedge clk);
    end

    cmpOn = 1'b0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule